// File: doc/BRIEF.md
# Auto-Incrementing Debug Memory Read Port

This block lets a debug host stream bytes out of system memory through a single register that never changes its address. Every host read of that register starts one memory fetch. The fetch address comes from a program counter register and the current addressing mode. When the byte comes back, it is returned to the host and the program counter moves forward by one. Repeated reads of the same register therefore walk through consecutive memory bytes.

The block has two addressing modes. In narrow mode a base-page byte supplies the top eight address bits, and only the low sixteen bits of the counter are used and advanced. In wide mode the full 24-bit counter is the address and is advanced as one value. The counter has its own load port, so the host can set the starting point. Memory is reached through a simple request/ready port, and the read data returns later with a valid strobe.

Top module: `dbg_memrd_port`

## Requirements
- R1: After reset `pc_value` is 000000h, and `busy`, `mem_req` and `host_rvalid` are all low.
- R2: A `host_rd` pulse while `busy` is low raises `mem_req` in the next cycle. `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_ready` is high.
- R3: When `wide_mode` is 0 (narrow mode), `mem_addr` equals {`base_page`, `pc_value`[15:0]}.
- R4: When `wide_mode` is 1 (wide mode), `mem_addr` equals `pc_value`[23:0].
- R5: The cycle after `mem_rvalid` is seen, `host_rvalid` is high for exactly one cycle and `host_rdata` holds the byte that was on `mem_rdata`.
- R6: Each completed read advances `pc_value` by one, so back-to-back reads return bytes from consecutive addresses.
- R7: In narrow mode only `pc_value`[15:0] advances, wrapping from FFFFh to 0000h, and `pc_value`[23:16] is left unchanged.
- R8: In wide mode `pc_value` advances as a 24-bit value and wraps from FFFFFFh to 000000h.
- R9: `busy` is high from the cycle after an accepted read until `host_rvalid` is asserted. A `host_rd` that arrives while `busy` is high is ignored: it starts no memory request and does not advance the counter.
- R10: A high `pc_wr_en` loads `pc_wr_data` into `pc_value` on the next edge. When a load and an advance fall in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe for the memory-read register |
| host_rdata | output | 8 | Byte returned to the host |
| host_rvalid | output | 1 | One-cycle strobe: `host_rdata` is valid |
| busy | output | 1 | A read is in progress |
| pc_wr_en | input | 1 | Load strobe for the program counter |
| pc_wr_data | input | 24 | Value to load into the program counter |
| pc_value | output | 24 | Current program counter |
| wide_mode | input | 1 | 1 = 24-bit addressing, 0 = base page plus 16-bit addressing |
| base_page | input | 8 | Upper address byte used in narrow mode |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read address |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Memory read data is valid |
| mem_rdata | input | 8 | Memory read data |

## Verification
The assertions assume that memory raises `mem_rvalid` only after it has accepted a request with `mem_ready`, and never in the same cycle as that acceptance. They also assume `wide_mode` and `base_page` do not change while `busy` is high. The bench's memory model obeys both: it raises `mem_rvalid` at least one cycle after the acceptance cycle, and it changes the mode and base page only while the block is idle. The bench drives a load in the same cycle as a returning byte only to exercise R10.

// File: rtl/dbg_memrd_pkg.sv
package dbg_memrd_pkg;
  localparam int unsigned DEF_PC_W   = 24;
  localparam int unsigned DEF_LOW_W  = 16;
  localparam int unsigned DEF_DATA_W = 8;

  // Sequencer phases
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_t;
endpackage

// File: rtl/dbg_addr_form.sv
module dbg_addr_form #(
  parameter int unsigned PC_W  = 24,
  parameter int unsigned LOW_W = 16,
  localparam int unsigned HI_W = PC_W - LOW_W
) (
  input  logic [PC_W-1:0] pc_in,
  input  logic            wide,
  input  logic [HI_W-1:0] page,
  output logic [PC_W-1:0] ea
);
  // Effective address: full counter, or page byte over low counter bits
  function automatic logic [PC_W-1:0] form_ea(
    input logic [PC_W-1:0] pc,
    input logic            w,
    input logic [HI_W-1:0] pg
  );
    if (w) return pc;
    return {pg, pc[LOW_W-1:0]};
  endfunction

  assign ea = form_ea(pc_in, wide, page);
endmodule

// File: rtl/dbg_pc_reg.sv
module dbg_pc_reg #(
  parameter int unsigned PC_W  = 24,
  parameter int unsigned LOW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [PC_W-1:0] ld_val,
  input  logic            step_en,
  input  logic            step_wide,
  output logic [PC_W-1:0] pc_q
);
  // Advance by one; narrow mode keeps the upper bits untouched
  function automatic logic [PC_W-1:0] step_pc(
    input logic [PC_W-1:0] pc,
    input logic            w
  );
    logic [LOW_W-1:0] lo;
    if (w) return pc + PC_W'(1);
    lo = pc[LOW_W-1:0] + LOW_W'(1);
    return {pc[PC_W-1:LOW_W], lo};
  endfunction

  logic [PC_W-1:0] pc_next;

  always_comb begin
    pc_next = pc_q;
    if (ld_en)        pc_next = ld_val;
    else if (step_en) pc_next = step_pc(pc_q, step_wide);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  // R10: a load always lands, even against an advance
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> pc_q == $past(ld_val));

  // R7: narrow advance leaves the upper bits alone
  p_upper_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_en && !step_wide) |=>
      pc_q[PC_W-1:LOW_W] == $past(pc_q[PC_W-1:LOW_W]));

  // R6: the counter changes on every advance
  p_step_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_en) |=> pc_q != $past(pc_q));

  // R6: the counter is steady without load or advance
  p_pc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !ld_en) |=> $stable(pc_q));
endmodule

// File: rtl/dbg_rd_seq.sv
module dbg_rd_seq
  import dbg_memrd_pkg::*;
#(
  parameter int unsigned PC_W   = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic [PC_W-1:0]   ea_in,
  input  logic              wide_in,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              busy,
  output logic              step_en,
  output logic              step_wide,
  output logic              accept_evt,
  output logic              rsp_evt
);
  sq_state_t st_q, st_d;
  logic      wide_q;

  assign busy       = (st_q != SQ_IDLE);
  assign accept_evt = host_rd && (st_q == SQ_IDLE);
  assign rsp_evt    = mem_rvalid && (st_q == SQ_WAIT);
  assign mem_req    = (st_q == SQ_REQ);
  assign step_en    = rsp_evt;
  assign step_wide  = wide_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (host_rd)    st_d = SQ_REQ;
      SQ_REQ:  if (mem_ready)  st_d = SQ_WAIT;
      SQ_WAIT: if (mem_rvalid) st_d = SQ_IDLE;
      default:                 st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= SQ_IDLE;
      wide_q      <= 1'b0;
      mem_addr    <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      st_q        <= st_d;
      host_rvalid <= rsp_evt;
      if (accept_evt) begin
        mem_addr <= ea_in;
        wide_q   <= wide_in;
      end
      if (rsp_evt) host_rdata <= mem_rdata;
    end
  end

  // R2: the request holds, with a steady address, until accepted
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R2: an accepted host read is followed by a request
  p_req_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> mem_req);

  // R5: the returned byte reaches the host one cycle later
  p_rsp_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_evt |=> (host_rvalid && host_rdata == $past(mem_rdata)));

  // R5: the host strobe lasts one cycle
  p_rvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);

  // R9: busy drops only as the byte is handed over
  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> host_rvalid);

  // R9: a strobe while busy leaves the request path untouched
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && busy && !mem_req) |=> !mem_req);
endmodule

// File: rtl/dbg_memrd_port.sv
module dbg_memrd_port
  import dbg_memrd_pkg::*;
#(
  parameter int unsigned PC_W   = DEF_PC_W,
  parameter int unsigned LOW_W  = DEF_LOW_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  localparam int unsigned HI_W  = PC_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              busy,
  input  logic              pc_wr_en,
  input  logic [PC_W-1:0]   pc_wr_data,
  output logic [PC_W-1:0]   pc_value,
  input  logic              wide_mode,
  input  logic [HI_W-1:0]   base_page,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [PC_W-1:0] ea_w;
  logic            step_en_w;
  logic            step_wide_w;
  logic            accept_evt_w;
  logic            rsp_evt_w;

  dbg_addr_form #(.PC_W(PC_W), .LOW_W(LOW_W)) u_addr (
    .pc_in (pc_value),
    .wide  (wide_mode),
    .page  (base_page),
    .ea    (ea_w)
  );

  dbg_pc_reg #(.PC_W(PC_W), .LOW_W(LOW_W)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (pc_wr_en),
    .ld_val    (pc_wr_data),
    .step_en   (step_en_w),
    .step_wide (step_wide_w),
    .pc_q      (pc_value)
  );

  dbg_rd_seq #(.PC_W(PC_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd     (host_rd),
    .ea_in       (ea_w),
    .wide_in     (wide_mode),
    .mem_ready   (mem_ready),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .busy        (busy),
    .step_en     (step_en_w),
    .step_wide   (step_wide_w),
    .accept_evt  (accept_evt_w),
    .rsp_evt     (rsp_evt_w)
  );

  // R3 / R4: the request carries the address of the accepted read
  p_addr_capture_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt_w && !pc_wr_en) |=> mem_addr == $past(ea_w));

  // R9: the counter only advances while a read is outstanding
  p_step_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_w |-> busy);
endmodule

// File: tb/dbg_memrd_port_tb.sv
module dbg_memrd_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        busy;
  logic        pc_wr_en = 1'b0;
  logic [23:0] pc_wr_data = '0;
  logic [23:0] pc_value;
  logic        wide_mode = 1'b0;
  logic [7:0]  base_page = '0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_pc = '0;

  always #2.5 clk = ~clk;

  dbg_memrd_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .busy(busy), .pc_wr_en(pc_wr_en),
    .pc_wr_data(pc_wr_data), .pc_value(pc_value), .wide_mode(wide_mode),
    .base_page(base_page), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [23:0] bench_addr(input logic [23:0] pc,
                                             input logic w, input logic [7:0] pg);
    logic [23:0] r;
    r = pc;
    if (!w) r[23:16] = pg;
    return r;
  endfunction

  function automatic logic [23:0] bench_next(input logic [23:0] pc, input logic w);
    if (w) return (pc == 24'hFFFFFF) ? 24'h0 : pc + 24'd1;
    return {pc[23:16], (pc[15:0] == 16'hFFFF) ? 16'h0 : pc[15:0] + 16'd1};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_pc(input logic [23:0] v);
    @(negedge clk);
    pc_wr_en = 1'b1; pc_wr_data = v;
    @(negedge clk);
    pc_wr_en = 1'b0;
    exp_pc = v;
    chk(pc_value == v, "R10 load", 32'(pc_value), 32'(v));
  endtask

  // poke: 0 none, 1 host_rd while busy, 2 load alongside the returning byte
  task automatic do_read(input int rdy_dly, input int lat, input int poke,
                         input logic [23:0] ldv, input string tag);
    logic [23:0] ea;
    ea = bench_addr(exp_pc, wide_mode, base_page);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    chk(mem_req == 1'b1, "R2 request raised", 32'(mem_req), 32'd1);
    chk(mem_addr == ea, tag, 32'(mem_addr), 32'(ea));
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      chk(mem_req && mem_addr == ea, "R2 request held", 32'(mem_addr), 32'(ea));
    end
    mem_ready = 1'b1;
    @(negedge clk); mem_ready = 1'b0;
    chk(busy == 1'b1, "R9 busy in flight", 32'(busy), 32'd1);
    if (poke == 1) begin
      host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
      chk(mem_req == 1'b0, "R9 strobe ignored", 32'(mem_req), 32'd0);
    end
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = mem_byte(ea);
    if (poke == 2) begin pc_wr_en = 1'b1; pc_wr_data = ldv; end
    @(negedge clk);
    mem_rvalid = 1'b0; pc_wr_en = 1'b0;
    chk(host_rvalid == 1'b1, "R5 rvalid", 32'(host_rvalid), 32'd1);
    chk(host_rdata == mem_byte(ea), "R5 rdata", 32'(host_rdata), 32'(mem_byte(ea)));
    chk(busy == 1'b0, "R9 busy cleared", 32'(busy), 32'd0);
    exp_pc = (poke == 2) ? ldv : bench_next(exp_pc, wide_mode);
    chk(pc_value == exp_pc, "R6 pc after read", 32'(pc_value), 32'(exp_pc));
    @(negedge clk);
    chk(host_rvalid == 1'b0, "R5 single pulse", 32'(host_rvalid), 32'd0);
    chk(mem_req == 1'b0, "R9 no extra request", 32'(mem_req), 32'd0);
  endtask

  task automatic t_reset();
    chk(pc_value == 24'h0, "R1 pc", 32'(pc_value), 32'd0);
    chk(!busy && !mem_req && !host_rvalid, "R1 flags",
        32'({busy, mem_req, host_rvalid}), 32'd0);
  endtask

  task automatic t_narrow_wrap();
    wide_mode = 1'b0; base_page = 8'hA5;
    load_pc(24'h12FFFE);
    do_read(0, 1, 0, '0, "R3 narrow address");
    do_read(2, 0, 0, '0, "R3 narrow address");
    chk(pc_value == 24'h120000, "R7 wrap keeps upper", 32'(pc_value), 32'h120000);
    do_read(1, 2, 0, '0, "R3 narrow address after wrap");
  endtask

  task automatic t_wide_wrap();
    wide_mode = 1'b1; base_page = 8'h5A;
    load_pc(24'hFFFFFE);
    do_read(0, 0, 0, '0, "R4 wide address");
    do_read(1, 1, 0, '0, "R4 wide address");
    chk(pc_value == 24'h000000, "R8 24-bit wrap", 32'(pc_value), 32'd0);
    do_read(0, 3, 0, '0, "R4 wide address after wrap");
  endtask

  task automatic t_stream();
    wide_mode = 1'b1;
    load_pc(24'h3410F0);
    for (int k = 0; k < 5; k++) do_read(k % 2, k % 3, 0, '0, "R6 sequential address");
    chk(pc_value == 24'h3410F5, "R6 five reads", 32'(pc_value), 32'h3410F5);
  endtask

  task automatic t_busy();
    wide_mode = 1'b0; base_page = 8'h07;
    load_pc(24'h000040);
    do_read(1, 2, 1, '0, "R9 address");
    chk(pc_value == 24'h000041, "R9 single advance", 32'(pc_value), 32'h41);
  endtask

  task automatic t_load_prio();
    wide_mode = 1'b1;
    load_pc(24'h00ABCD);
    do_read(0, 1, 2, 24'h777000, "R10 address");
    chk(pc_value == 24'h777000, "R10 load beats advance", 32'(pc_value), 32'h777000);
    do_read(0, 0, 0, '0, "R10 read from loaded pc");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_wrap();
    t_wide_wrap();
    t_stream();
    t_busy();
    t_load_prio();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule